// File: doc/BRIEF.md
# Guard Timer with Keyed Service Sequence

The guard timer is a bus-mapped supervisor that asks for a chip reset when software stops servicing it. Its single clock passes through a fixed divide-by-four prescaler. Each prescaled tick lowers a 24-bit down-counter. Software reloads the counter through a two-write service sequence: 0xAA, then 0x55 on the very next bus write. The reload value comes from a reload register. Its lower bound is 0xFF and its upper bound is 0xFFFFFF. Values written outside that range are clamped to the nearest bound.

Software first sets the enable bit in the control register. The timer becomes active only when a valid service sequence completes after that. From then on it cannot be stopped, and the control bits can no longer be cleared. While the timer is active and reset-on-expiry is selected, two events raise a one-cycle reset request. One is a broken service sequence. The other is the counter running out. Every expiry also sets a sticky expiry flag. The reset generator that acts on the request lies outside this block.

Register offsets on the byte-addressed bus:

| Offset | Register |
|---|---|
| 0x0 | control (bit 0 enable, bit 1 reset-on-expiry) |
| 0x4 | reload value |
| 0x8 | service (write only) |
| 0xC | current count (read only) |

Reads are combinational from the address.

Top module: `guard_timer`

## Requirements
- R1: After reset, the reload and count registers both read 0xFF, the control register reads 0, and `rst_req` and `timeout_flag` are low.
- R2: A write to offset 0x4 stores the full 32-bit data clamped into [0xFF, 0xFFFFFF]. Such a write does not change the count.
- R3: While the timer is not active, the count register holds its value, and a set enable bit alone starts nothing.
- R4: A service sequence is a write of 0xAA (data bits 7:0) to offset 0x8, followed by 0x55 as the next bus write to offset 0x8. A completed sequence loads the count from the reload register. If the enable bit (control bit 0) is set, it also makes the timer active.
- R5: While the timer is active, the count drops by exactly one every 4 clock cycles.
- R6: While the timer is active, a tick that finds the count at 0 reloads the count and sets the sticky `timeout_flag`. If control bit 1 is set, it also pulses `rst_req` high for one cycle. That pulse comes 4·reload+1 to 4·reload+4 cycles after the servicing write.
- R7: With control bit 1 clear, an expiry sets `timeout_flag` without raising `rst_req`.
- R8: While the timer is active with control bit 1 set, any of the following raises `rst_req` in the cycle after the offending write:
  - a service-register write that is not 0xAA at the start of a sequence;
  - a write after 0xAA other than 0x55 to offset 0x8, including a write to another register.
- R9: A broken service sequence while the timer is inactive raises no reset.
- R10: Before activation, the control register is freely writable. Once the timer is active, writes can set control bits but not clear them, until system reset.
- R11: Writes to offset 0xC do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counter |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle chip reset request |
| timeout_flag | output | 1 | Sticky expiry indication |

## Verification
The bench goes after the service-sequence corner cases:
- a repeated 0xAA;
- a stray reload-register write between the two keys;
- a lone 0x55.

A design that treated any of these as harmless would let a runaway program keep the timer alive. The bench also probes arming: setting enable without servicing must not start counting, and servicing without enable must only reload. Getting either wrong produces resets that software never asked for. The reload clamp is swept at both bounds, across the 32-bit width, because a missed clamp gives expiry periods far shorter or longer than intended. Expiry timing is measured against four reload values; an off-by-one in the zero handling shifts each period by a whole prescaled tick.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam int unsigned OFS_CTRL   = 0;
   localparam int unsigned OFS_RELOAD = 4;
   localparam int unsigned OFS_SVC    = 8;
   localparam int unsigned OFS_COUNT  = 12;
   typedef enum logic {SVC_IDLE, SVC_HALF} svc_state_e;
endpackage

// File: rtl/gtm_prescale.sv
module gtm_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] ph_q;

   if (DIV < 2) begin : g_bad_div
      $error("gtm_prescale: DIV must be at least 2");
   end

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) ph_q <= '0;
         else        ph_q <= ph_q + PW'(1);
      assign tick = &ph_q;
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)          ph_q <= '0;
         else if (ph_q == LAST) ph_q <= '0;
         else                 ph_q <= ph_q + PW'(1);
      assign tick = (ph_q == LAST);
   end

   // R5: ticks never come back to back
   p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/gtm_svc_seq.sv
module gtm_svc_seq
   import gtm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_is_svc,
   input  logic [7:0] wr_byte,
   output logic       svc_ok,
   output logic       svc_bad
);
   svc_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      svc_ok  = 1'b0;
      svc_bad = 1'b0;
      if (wr_en) begin
         if (st_q == SVC_IDLE) begin
            if (wr_is_svc && wr_byte == KEY_FIRST) st_d = SVC_HALF;
            else if (wr_is_svc)                    svc_bad = 1'b1;
         end else begin
            st_d = SVC_IDLE;
            if (wr_is_svc && wr_byte == KEY_SECOND) svc_ok  = 1'b1;
            else                                    svc_bad = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_q <= SVC_IDLE;
      else        st_q <= st_d;

   // R4/R8: a verdict always returns the sequence to its start
   p_verdict_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ok || svc_bad) |=> st_q == SVC_IDLE);
   p_verdict_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(svc_ok && svc_bad));
endmodule

// File: rtl/gtm_down_cnt.sv
module gtm_down_cnt #(
   parameter int unsigned W       = 24,
   parameter int unsigned RST_VAL = 255
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         expire
);
   assign expire = run && tick && !load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= W'(RST_VAL);
      else if (load)       cnt <= load_val;
      else if (run && tick) cnt <= (cnt == '0) ? load_val : cnt - W'(1);

   // R3: an idle counter with no load does not move
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt));
   // R5: no change between ticks unless loaded
   p_still_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import gtm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned CNT_W   = 24,
   parameter int unsigned PRE_DIV = 4,
   parameter int unsigned TC_MIN  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic              timeout_flag
);
   localparam logic [CNT_W-1:0]  MIN_V = CNT_W'(TC_MIN);
   localparam logic [CNT_W-1:0]  MAX_V = '1;
   localparam logic [DATA_W-1:0] MAX_D = DATA_W'(MAX_V);

   if (CNT_W < 9 || DATA_W < CNT_W) begin : g_bad_width
      $error("guard_timer: counter must be 9..DATA_W bits");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("guard_timer: ADDR_W too small for the register map");
   end

   logic [1:0]       mode_q;
   logic [CNT_W-1:0] tc_q;
   logic             active_q, rst_req_q, flag_q;
   logic             tick, svc_ok, svc_bad, expire;
   logic [CNT_W-1:0] cnt;

   logic wr_ctrl, wr_reload, wr_svc;
   assign wr_ctrl   = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
   assign wr_reload = bus_we && bus_addr == ADDR_W'(OFS_RELOAD);
   assign wr_svc    = bus_addr == ADDR_W'(OFS_SVC);

   gtm_prescale #(.DIV(PRE_DIV)) i_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   gtm_svc_seq i_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_is_svc(wr_svc),
      .wr_byte(bus_wdata[7:0]), .svc_ok(svc_ok), .svc_bad(svc_bad));

   gtm_down_cnt #(.W(CNT_W), .RST_VAL(TC_MIN)) i_cnt (
      .clk(clk), .rst_n(rst_n), .load(svc_ok), .load_val(tc_q),
      .run(active_q), .tick(tick), .cnt(cnt), .expire(expire));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mode_q    <= '0;
         tc_q      <= MIN_V;
         active_q  <= 1'b0;
         rst_req_q <= 1'b0;
         flag_q    <= 1'b0;
      end else begin
         if (wr_ctrl)
            mode_q <= active_q ? (mode_q | bus_wdata[1:0]) : bus_wdata[1:0];
         if (wr_reload) begin
            if (bus_wdata > MAX_D)                 tc_q <= MAX_V;
            else if (bus_wdata < DATA_W'(MIN_V))   tc_q <= MIN_V;
            else                                   tc_q <= bus_wdata[CNT_W-1:0];
         end
         active_q  <= active_q | (svc_ok & mode_q[0]);
         rst_req_q <= mode_q[1] & ((svc_bad & active_q) | expire);
         flag_q    <= flag_q | expire;
      end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL):   bus_rdata[1:0]       = mode_q;
         ADDR_W'(OFS_RELOAD): bus_rdata[CNT_W-1:0] = tc_q;
         ADDR_W'(OFS_COUNT):  bus_rdata[CNT_W-1:0] = cnt;
         default:             bus_rdata            = '0;
      endcase
   end

   assign rst_req      = rst_req_q;
   assign timeout_flag = flag_q;

   // R4: activation only follows a completed service sequence
   p_arm_needs_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> $past(svc_ok));
   // R10: once active, stays active and control bits never clear
   p_active_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> active_q);
   p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> (($past(mode_q) & ~mode_q) == 2'b00));
   // R2: reload value never below the floor
   p_tc_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q >= MIN_V);
   // R6: expiry flag is sticky
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);
   // R7/R8: a reset request needs reset-on-expiry selected
   p_req_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |-> $past(mode_q[1]));
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req, timeout_flag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   guard_timer i_guard_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req), .timeout_flag(timeout_flag));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_we = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic feed();
      wr(4'h8, 32'hAA);
      wr(4'h8, 32'h55);
   endtask

   function automatic logic [31:0] clamp(input logic [31:0] v);
      if (v > 32'hFFFFFF) return 32'hFFFFFF;
      if (v < 32'hFF)     return 32'hFF;
      return v;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] sweep [10];
      logic [31:0] tcs [4];
      sweep = '{32'h0, 32'h1, 32'h10, 32'hFE, 32'hFF, 32'h100,
                32'hABCDE, 32'hFFFFFF, 32'h1000000, 32'hFFFFFFFF};
      tcs = '{32'hFF, 32'h100, 32'h17F, 32'h200};

      // R1 reset state
      do_reset();
      rd(4'h4, d); chk("R1 reload", d, 32'hFF);
      rd(4'hC, d); chk("R1 count", d, 32'hFF);
      rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
      chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
      chk("R1 flag", {31'b0, timeout_flag}, 32'h0);

      // R2 clamp sweep, count untouched
      foreach (sweep[i]) begin
         wr(4'h4, sweep[i]);
         rd(4'h4, d); chk("R2 clamp", d, clamp(sweep[i]));
      end
      rd(4'hC, d); chk("R2 count untouched", d, 32'hFF);

      // R11 count is read-only
      wr(4'hC, 32'h1234);
      rd(4'hC, d); chk("R11 count write ignored", d, 32'hFF);

      // R10 free control before activation
      wr(4'h0, 32'h3); wr(4'h0, 32'h0);
      rd(4'h0, d); chk("R10 ctrl writable before arm", d, 32'h0);

      // R3 enable alone starts nothing
      wr(4'h0, 32'h3);
      repeat (40) @(negedge clk);
      rd(4'hC, d); chk("R3 count holds", d, 32'hFF);
      // R9 broken sequence while inactive
      wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
      chk("R9 no reset inactive", {31'b0, rst_req}, 32'h0);

      // R4 feed without enable reloads only
      do_reset();
      wr(4'h0, 32'h2); wr(4'h4, 32'h300); feed();
      rd(4'hC, d); chk("R4 reload no enable", d, 32'h300);
      repeat (40) @(negedge clk);
      rd(4'hC, d); chk("R4 not armed without enable", d, 32'h300);
      wr(4'h8, 32'h55);
      chk("R9 lone 0x55 inactive", {31'b0, rst_req}, 32'h0);

      // R5 count rate, R10 lock
      do_reset();
      wr(4'h0, 32'h3); wr(4'h4, 32'h400); feed();
      repeat (40) @(negedge clk);
      rd(4'hC, d); chk("R5 ten ticks in 40 cycles", d, 32'h400 - 10);
      wr(4'h0, 32'h0);
      rd(4'h0, d); chk("R10 ctrl locked", d, 32'h3);

      // R6 expiry timing sweep with reset select
      foreach (tcs[i]) begin
         int n;
         do_reset();
         wr(4'h0, 32'h3); wr(4'h4, tcs[i]); feed();
         n = 0;
         while (!rst_req && n < 10000) begin @(negedge clk); n++; end
         chk_rng("R6 expiry delay", n, 4*int'(tcs[i])+1, 4*int'(tcs[i])+4);
         chk("R6 flag set", {31'b0, timeout_flag}, 32'h1);
         rd(4'hC, d); chk("R6 reload on expiry", d, tcs[i]);
         @(negedge clk);
         chk("R6 one-cycle pulse", {31'b0, rst_req}, 32'h0);
      end

      // R7 expiry without reset select
      begin
         int n;
         int seen;
         do_reset();
         wr(4'h0, 32'h1); feed();
         n = 0; seen = 0;
         while (!timeout_flag && n < 10000) begin
            @(negedge clk); n++;
            if (rst_req) seen++;
         end
         chk_rng("R7 expiry delay", n, 4*255+1, 4*255+4);
         chk("R7 no reset", seen, 0);
         rd(4'hC, d); chk("R7 counter reloaded", d, 32'hFF);
      end

      // R8 broken sequences while active
      do_reset();
      wr(4'h0, 32'h3); feed();
      wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
      chk("R8 double 0xAA", {31'b0, rst_req}, 32'h1);
      @(negedge clk);
      chk("R8 pulse ends", {31'b0, rst_req}, 32'h0);

      do_reset();
      wr(4'h0, 32'h3); feed();
      wr(4'h8, 32'hAA);
      chk("R8 half sequence no reset", {31'b0, rst_req}, 32'h0);
      wr(4'h4, 32'h300);
      chk("R8 stray write breaks", {31'b0, rst_req}, 32'h1);

      do_reset();
      wr(4'h0, 32'h3); feed();
      chk("R4 good feed no reset", {31'b0, rst_req}, 32'h0);
      wr(4'h8, 32'h55);
      chk("R8 lone 0x55", {31'b0, rst_req}, 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule